// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire PHY management bus (MDC clock, bidirectional MDIO data). It runs Clause 22 read and write frames and a repeating scan mode. It derives MDC from the system clock through a 4-bit divider code whose ratios are not linear. Software works through a small bank of 32-bit registers. It sets a PHY and register address, and then does one of three things. Writing a 16-bit value to the data-out register starts a write frame. Raising the read bit in the command register starts a read frame. Setting the scan bit makes the block poll the same register without pause.

Register offsets used by the block: 0x00 configuration, 0x04 command, 0x08 address, 0x0C write data, 0x10 read data, 0x14 indication, 0x34 internal PHY address. The engine drives MDIO through a separate output enable, so the pad-level tri-state buffer stays outside the block. MDIO changes only on falling MDC edges. Read data is taken on rising edges.

Top module: `mdio_master`

## Requirements
- R1: Register map (byte offsets). 0x00 holds the configuration bits 4:0 and reads bit 31 as 0. 0x04 holds command bits 1:0. 0x08 holds the PHY address in bits 12:8 and the register number in bits 4:0. 0x0C holds the write data in bits 15:0. 0x10 returns read data in bits 15:0. 0x14 returns the indication: bit0 busy, bit1 scanning, bit2 read-data-not-valid. 0x34 holds a 5-bit internal PHY address. Every other offset reads 0. `bus_rdata` shows the register addressed in the previous cycle.
- R2: Writing offset 0x0C starts a write frame. The frame is sent MSB first: 32 ones, 01, opcode 01, 5-bit PHY address, 5-bit register number, turnaround 10, then 16 data bits.
- R3: A read frame starts only when a command write takes bit 0 from 0 to 1. Writing 1 over an existing 1 starts nothing. A read frame uses opcode 10, and the master drives it only up to the register number. `mdio_oe` is low from the turnaround through the last data bit.
- R4: Read data is captured from `mdio_i` on the rising MDC edges of the 16 data bits, MSB first, into offset 0x10. Not-valid (indication bit2) goes high when a read starts and stays high until that data is stored.
- R5: With configuration bit 4 set, the 32 preamble bits are skipped, so a frame has 32 MDC cycles instead of 64.
- R6: MDC half period in system clocks is half the ratio chosen by configuration bits 3:0. Codes 0 to 15 select ratios 2, 4, 6, 8, 10, 14, 20, 28, 16, 32, 48, 64, 80, 112, 160, 224. MDC is low whenever no frame is running.
- R7: `mdio_o` and `mdio_oe` never change while MDC stays high. They change only at a falling MDC edge, at frame start or at abort.
- R8: Busy is high from frame start until the final falling MDC edge. Data-out writes and read-bit edges that arrive while busy start no frame.
- R9: While command bit 1 is set, the block issues read frames back to back and updates offset 0x10 after each one. Indication bit1 is high while scan is requested or a scan frame is still running. Clearing bit 1 lets the current frame finish, and then no more frames start.
- R10: A configuration write with bit 31 set aborts any frame. In the next cycle busy, MDC and `mdio_oe` are low, and the command bits are cleared. The same write stores bits 4:0.
- R11: Synchronous reset leaves all registers at 0, except the internal PHY address, which resets to 0x1F. MDC and `mdio_oe` are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data of the offset given in the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data sampled from the pad |

## Verification
The bound checker watches several properties on every cycle:
- MDC stays low outside frames.
- Data and enable hold steady while MDC is high.
- The enable is released when idle.
- Not-valid covers every running read.
- A reset write silences the bus in the next cycle.

Only the bench scenarios can show the behaviour that needs a whole frame:
- the bit-exact frame contents and the turnaround release;
- the captured read value;
- the divider half-periods for chosen codes;
- edge-only read starts and the requests dropped while busy;
- scan stopping only on a frame boundary.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int HALF_W  = 8;
  localparam int OFS_CFG = 'h00;
  localparam int OFS_CMD = 'h04;
  localparam int OFS_ADR = 'h08;
  localparam int OFS_CTL = 'h0C;
  localparam int OFS_STA = 'h10;
  localparam int OFS_IND = 'h14;
  localparam int OFS_TBI = 'h34;

  // R6: half MDC period in system clocks for each divider code
  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] code);
    case (code)
      4'd0:    half_period = 8'd1;
      4'd1:    half_period = 8'd2;
      4'd2:    half_period = 8'd3;
      4'd3:    half_period = 8'd4;
      4'd4:    half_period = 8'd5;
      4'd5:    half_period = 8'd7;
      4'd6:    half_period = 8'd10;
      4'd7:    half_period = 8'd14;
      4'd8:    half_period = 8'd8;
      4'd9:    half_period = 8'd16;
      4'd10:   half_period = 8'd24;
      4'd11:   half_period = 8'd32;
      4'd12:   half_period = 8'd40;
      4'd13:   half_period = 8'd56;
      4'd14:   half_period = 8'd80;
      default: half_period = 8'd112;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          mdc,
  output logic          rise_tk,
  output logic          fall_tk
);
  logic [HW-1:0] cnt;
  logic          wrap;

  assign wrap    = run && (cnt == half - 1'b1);
  assign rise_tk = wrap && !mdc;
  assign fall_tk = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
  parameter int PL = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        abort,
  input  logic        is_read,
  input  logic        pre_skip,
  input  logic [4:0]  phy,
  input  logic [4:0]  reg_num,
  input  logic [15:0] wdata,
  input  logic        rise_tk,
  input  logic        fall_tk,
  input  logic        mdio_i,
  output logic        busy,
  output logic        rd_frame,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rd_data
);
  localparam int FL = PL + 32;
  localparam int PW = $clog2(FL);
  localparam int TP = PL + 14;
  localparam int DP = PL + 16;

  logic [FL-1:0] sh;
  logic [FL-1:0] frame_w;
  logic [PW-1:0] pos;
  logic [15:0]   rd_sh;
  logic          last;

  assign frame_w = {{PL{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), phy, reg_num,
                    (is_read ? 2'b11 : 2'b10), (is_read ? 16'hFFFF : wdata)};
  assign last    = (pos == PW'(FL - 1));
  assign mdio_o  = sh[FL-1];
  assign rd_data = rd_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      rd_frame <= 1'b0;
      mdio_oe  <= 1'b0;
      rd_done  <= 1'b0;
      sh       <= '0;
      pos      <= '0;
      rd_sh    <= '0;
    end else begin
      rd_done <= 1'b0;
      if (abort) begin                       // R10
        busy     <= 1'b0;
        rd_frame <= 1'b0;
        mdio_oe  <= 1'b0;
        sh       <= '0;
      end else if (start) begin              // R2 R3 R5
        busy     <= 1'b1;
        rd_frame <= is_read;
        mdio_oe  <= 1'b1;
        pos      <= pre_skip ? PW'(PL) : '0;
        sh       <= pre_skip ? (frame_w << PL) : frame_w;
      end else if (busy) begin
        if (rise_tk && rd_frame && (pos >= PW'(DP)))
          rd_sh <= {rd_sh[14:0], mdio_i};    // R4
        if (fall_tk) begin                   // R7: change only on falling MDC
          if (last) begin
            busy     <= 1'b0;
            rd_frame <= 1'b0;
            mdio_oe  <= 1'b0;
            sh       <= '0;
            rd_done  <= rd_frame;
          end else begin
            pos     <= pos + 1'b1;
            sh      <= sh << 1;
            mdio_oe <= !(rd_frame && ((pos + 1'b1) >= PW'(TP)));  // R3
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic [4:0]  cfg_q;
  logic [1:0]  cmd_q;
  logic [4:0]  phy_q;
  logic [4:0]  rnum_q;
  logic [15:0] ctl_q;
  logic [15:0] sta_q;
  logic        nv_q;
  logic [4:0]  tbi_q;
  logic        scan_run_q;

  logic        eng_busy, eng_rd, eng_done;
  logic [15:0] eng_data;
  logic        rise_tk, fall_tk;
  logic [HALF_W-1:0] half;

  logic wr_cfg, wr_cmd, wr_adr, wr_ctl, wr_tbi;
  logic mgmt_rst, rd_edge, start, start_rd, scan_ind;
  logic unused_bits;

  assign unused_bits = ^{bus_wdata[30:16], bus_wdata[7:5]};

  assign wr_cfg = bus_we && (bus_addr == ADDR_W'(OFS_CFG));
  assign wr_cmd = bus_we && (bus_addr == ADDR_W'(OFS_CMD));
  assign wr_adr = bus_we && (bus_addr == ADDR_W'(OFS_ADR));
  assign wr_ctl = bus_we && (bus_addr == ADDR_W'(OFS_CTL));
  assign wr_tbi = bus_we && (bus_addr == ADDR_W'(OFS_TBI));

  assign mgmt_rst = wr_cfg && bus_wdata[31];                 // R10
  assign rd_edge  = wr_cmd && bus_wdata[0] && !cmd_q[0];     // R3
  assign start    = !eng_busy && !mgmt_rst && (wr_ctl || rd_edge || cmd_q[1]);  // R8 R9
  assign start_rd = !wr_ctl;
  assign scan_ind = cmd_q[1] || (eng_busy && scan_run_q);    // R9
  assign half     = half_period(cfg_q[3:0]);                 // R6

  mdio_clkgen #(.HW(HALF_W)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .run     (eng_busy && !mgmt_rst),
    .half    (half),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdio_frame #(.PL(PRE_LEN)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .abort    (mgmt_rst),
    .is_read  (start_rd),
    .pre_skip (cfg_q[4]),
    .phy      (phy_q),
    .reg_num  (rnum_q),
    .wdata    (wr_ctl ? bus_wdata[15:0] : ctl_q),
    .rise_tk  (rise_tk),
    .fall_tk  (fall_tk),
    .mdio_i   (mdio_i),
    .busy     (eng_busy),
    .rd_frame (eng_rd),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_done  (eng_done),
    .rd_data  (eng_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin                           // R11
      cfg_q      <= '0;
      cmd_q      <= '0;
      phy_q      <= '0;
      rnum_q     <= '0;
      ctl_q      <= '0;
      sta_q      <= '0;
      nv_q       <= 1'b0;
      tbi_q      <= 5'h1F;
      scan_run_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata[4:0];
      if (mgmt_rst)    cmd_q <= '0;
      else if (wr_cmd) cmd_q <= bus_wdata[1:0];
      if (wr_adr) begin
        phy_q  <= bus_wdata[12:8];
        rnum_q <= bus_wdata[4:0];
      end
      if (wr_ctl) ctl_q <= bus_wdata[15:0];
      if (wr_tbi) tbi_q <= bus_wdata[4:0];
      if (start && start_rd) nv_q <= 1'b1;   // R4
      else if (eng_done)     nv_q <= 1'b0;
      if (eng_done) sta_q <= eng_data;
      if (mgmt_rst)   scan_run_q <= 1'b0;
      else if (start) scan_run_q <= start_rd && cmd_q[1];
    end
  end

  // R1: registered read mux
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        ADDR_W'(OFS_CFG): bus_rdata <= {27'd0, cfg_q};
        ADDR_W'(OFS_CMD): bus_rdata <= {30'd0, cmd_q};
        ADDR_W'(OFS_ADR): bus_rdata <= {19'd0, phy_q, 3'd0, rnum_q};
        ADDR_W'(OFS_CTL): bus_rdata <= {16'd0, ctl_q};
        ADDR_W'(OFS_STA): bus_rdata <= {16'd0, sta_q};
        ADDR_W'(OFS_IND): bus_rdata <= {29'd0, nv_q, scan_ind, eng_busy};
        ADDR_W'(OFS_TBI): bus_rdata <= {27'd0, tbi_q};
        default:          bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              busy,
  input logic              rd_frame,
  input logic              not_valid
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);  // R6
  AST_RISE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> busy);  // R8
  AST_MDIO_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));  // R7
  AST_OE_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);  // R3
  AST_NOTVALID_READ: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_frame) |-> not_valid);  // R4
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (bus_addr == '0) && bus_wdata[31]) |=> (!busy && !mdc && !mdio_oe));  // R10
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (eng_busy),
  .rd_frame  (eng_rd),
  .not_valid (nv_q)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        bus_we = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1;

  mdio_master uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  // monitor / PHY model state
  int hi_cnt = 0, lo_cnt = 0, rif = 0, ncap = 0, width_err = 0, r7_err = 0;
  int exp_half = 1, mon_p0 = 0;
  bit width_en = 1;
  logic [15:0] phy_val = 16'h0000;
  logic cap_o [0:63];
  logic cap_oe [0:63];
  logic mdc_p = 0, o_p = 0, oe_p = 0;
  int ratio [16] = '{2, 4, 6, 8, 10, 14, 20, 28, 16, 32, 48, 64, 80, 112, 160, 224};

  always @(negedge clk) begin
    if (!rst) begin
      if (mdc && !mdc_p) begin
        if (width_en && rif != 0 && lo_cnt != exp_half) width_err++;
        lo_cnt = 0;
        if (ncap < 64) begin
          cap_o[ncap]  = mdio_o;
          cap_oe[ncap] = mdio_oe;
        end
        ncap++;
        rif = (rif + 1 == 64 - mon_p0) ? 0 : rif + 1;
      end
      if (!mdc && mdc_p) begin
        if (width_en && hi_cnt != exp_half) width_err++;
        hi_cnt = 0;
      end
      if (mdc && mdc_p && (mdio_o !== o_p || mdio_oe !== oe_p)) r7_err++;
      if (mdc) hi_cnt++; else lo_cnt++;
      begin
        int p;
        p = mon_p0 + rif;
        mdio_i = (p >= 48) ? phy_val[63 - p] : 1'b1;
      end
    end
    mdc_p = mdc; o_p = mdio_o; oe_p = mdio_oe;
  end

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic mon_reset(input int half, input int p0);
    @(posedge clk);
    exp_half = half; mon_p0 = p0;
    rif = 0; ncap = 0; hi_cnt = 0; lo_cnt = 0; width_err = 0; r7_err = 0;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] d;
    d = 32'h1;
    for (int i = 0; i < 8000 && d[0]; i++) reg_read(6'h14, d);
    chk_eq(req, "busy clears", d[0], 0);
  endtask

  task automatic cmp_frame(input string req, input bit rd, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] data);
    logic [63:0] ev;
    int mism, n;
    ev = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
          (rd ? 2'b11 : 2'b10), data};
    n = 64 - mon_p0;
    mism = 0;
    for (int i = 0; i < n; i++) begin
      bit eoe;
      eoe = !(rd && (mon_p0 + i) >= 46);
      if (cap_oe[i] !== eoe) mism++;
      else if (eoe && cap_o[i] !== ev[63 - mon_p0 - i]) mism++;
    end
    chk_eq(req, "frame bit mismatches", mism, 0);
    chk_eq(req, "MDC rising edges per frame", ncap, n);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 0;

    // Reset state (R11, R1)
    reg_read(6'h00, d); chk_eq("R11", "cfg reset", d, 0);
    reg_read(6'h04, d); chk_eq("R11", "cmd reset", d, 0);
    reg_read(6'h14, d); chk_eq("R11", "indication reset", d, 0);
    reg_read(6'h10, d); chk_eq("R11", "read data reset", d, 0);
    reg_read(6'h34, d); chk_eq("R11", "internal PHY addr reset", d, 32'h1F);
    chk_eq("R11", "mdc and oe after reset", {mdc, mdio_oe}, 0);

    // Register map (R1)
    reg_write(6'h34, 32'h0000_0003);
    reg_read(6'h34, d); chk_eq("R1", "internal PHY addr", d, 3);
    reg_write(6'h08, 32'hFFFF_FFFF);
    reg_read(6'h08, d); chk_eq("R1", "address fields", d, 32'h1F1F);
    reg_write(6'h00, 32'hFFFF_FFFF);
    reg_read(6'h00, d); chk_eq("R1", "cfg bit31 reads 0", d, 32'h1F);
    reg_read(6'h18, d); chk_eq("R1", "unmapped offset", d, 0);
    chk_eq("R1", "no frame from register setup", ncap, 0);

    // Write frame with preamble, divide by 2 (R2, R6, R8, R7)
    reg_write(6'h00, 32'h0);
    reg_write(6'h04, 32'h0);
    mon_reset(1, 0);
    reg_write(6'h08, (5 << 8) | 32'h0A);
    reg_write(6'h0C, 32'h0000_BEEF);
    repeat (20) @(negedge clk);
    reg_write(6'h0C, 32'h0000_1111);  // ignored while busy
    reg_write(6'h04, 32'h0);
    reg_write(6'h04, 32'h1);          // read edge ignored while busy
    wait_idle("R8");
    cmp_frame("R2", 0, 5'd5, 5'h0A, 16'hBEEF);
    chk_eq("R6", "half period code 0", width_err, 0);
    chk_eq("R7", "mdio moved while mdc high", r7_err, 0);
    repeat (100) @(negedge clk);
    chk_eq("R8", "no frame from requests while busy", ncap, 64);
    chk_eq("R6", "mdc low when idle", mdc, 0);

    // No read without a 0->1 edge (R3)
    mon_reset(1, 0);
    reg_write(6'h04, 32'h1);
    repeat (60) @(negedge clk);
    chk_eq("R3", "rewrite of 1 starts nothing", ncap, 0);

    // Read frame, preamble skipped, code 3 (R3, R4, R5)
    reg_write(6'h00, 32'h13);
    phy_val = 16'h1234;
    mon_reset(4, 32);
    reg_write(6'h08, (32'h11 << 8) | 32'h03);
    reg_write(6'h04, 32'h0);
    reg_write(6'h04, 32'h1);
    reg_read(6'h14, d);
    chk_eq("R4", "busy and not-valid during read", d[2:0], 3'b101);
    wait_idle("R4");
    cmp_frame("R3", 1, 5'h11, 5'h03, 16'hFFFF);
    chk_eq("R5", "short frame length", ncap, 32);
    chk_eq("R6", "half period code 3", width_err, 0);
    reg_read(6'h10, d); chk_eq("R4", "read data", d, 32'h1234);
    reg_read(6'h14, d); chk_eq("R4", "not-valid cleared", d, 0);

    // Divider codes (R6)
    foreach (ratio[k]) begin
      if (k == 5 || k == 8 || k == 13 || k == 15) begin
        reg_write(6'h00, 32'h10 | k);
        mon_reset(ratio[k] / 2, 32);
        reg_write(6'h0C, 32'h0000_0F0F);
        wait_idle("R6");
        chk_eq("R6", $sformatf("half period errors code %0d", k), width_err, 0);
        chk_eq("R6", $sformatf("edges code %0d", k), ncap, 32);
      end
    end

    // Scan (R9)
    reg_write(6'h04, 32'h0);
    reg_write(6'h00, 32'h11);
    phy_val = 16'hA5A5;
    mon_reset(2, 32);
    reg_write(6'h04, 32'h2);
    reg_read(6'h14, d); chk_eq("R9", "scan indication", d[1], 1);
    wait (ncap >= 32);
    phy_val = 16'h5A5A;
    wait (ncap >= 64);
    repeat (10) @(negedge clk);
    reg_read(6'h10, d); chk_eq("R9", "status updated by repeat read", d, 32'h5A5A);
    reg_write(6'h04, 32'h0);
    wait_idle("R9");
    reg_read(6'h14, d); chk_eq("R9", "indication after stop", d, 0);
    n = ncap;
    repeat (100) @(negedge clk);
    chk_eq("R9", "no frames after stop", ncap, n);
    chk_eq("R9", "stopped on frame boundary", ncap % 32, 0);
    chk_eq("R6", "scan half period", width_err, 0);

    // Management reset mid-frame (R10)
    reg_write(6'h00, 32'h02);
    mon_reset(3, 0);
    reg_write(6'h0C, 32'h0000_7777);
    repeat (40) @(negedge clk);
    width_en = 0;
    reg_write(6'h00, 32'h8000_0002);
    chk_eq("R10", "mdc and oe after abort", {mdc, mdio_oe}, 0);
    reg_read(6'h14, d); chk_eq("R10", "indication after abort", d[1:0], 0);
    reg_read(6'h00, d); chk_eq("R10", "cfg stored by reset write", d, 2);
    reg_read(6'h04, d); chk_eq("R10", "command cleared", d, 0);
    mon_reset(3, 0);
    width_en = 1;
    reg_write(6'h0C, 32'h0000_2222);
    wait_idle("R10");
    cmp_frame("R10", 0, 5'h11, 5'h03, 16'h2222);
    chk_eq("R10", "half period after abort", width_err, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule